// File: doc/BRIEF.md
# Mains Presence Timeout Monitor

The block decides whether an AC supply is present by looking at the digital output of an external comparator. The comparator is high while the rectified half-wave sample of the mains exceeds a reference, so a healthy supply gives one high-to-low transition per mains period. The comparator level first passes a synchroniser and then a glitch filter. Each falling edge of the filtered level restarts a retriggerable countdown. While the countdown is running, the supply is reported present. When it runs out with no new falling edge, the supply is reported failed.

A failure raises a sticky interrupt level at the moment presence is lost. The interrupt stays asserted until the supply returns, which is marked by the next qualified falling edge, or until reset. The countdown length is a parameter. It must be longer than one mains period, because the comparator gives only one usable edge per cycle. The default is 27 ms at a 250 MHz clock.

Top module: `mains_presence_monitor`

## Requirements
- R1: After reset `ac_present` and `ac_fail_irq` are 0. `ac_present` stays 0 under steady levels and rising transitions until the first qualified falling edge of the comparator level.
- R2: A qualified falling edge of `cmp_level` sets `ac_present` to 1 within SYNC_STAGES + FILT_LEN + 2 clock cycles of the edge being driven.
- R3: While every qualified falling edge follows the previous one by at most TIMEOUT_CYCLES cycles, `ac_present` stays 1 without a gap.
- R4: Only falling edges restart the countdown; rising edges and steady levels do not. TIMEOUT_CYCLES + 1 cycles after the countdown was last loaded, with no new falling edge, `ac_present` drops to 0.
- R5: `ac_fail_irq` rises only in the cycle in which `ac_present` falls. It then stays at 1 for as long as `ac_present` is 0.
- R6: `ac_fail_irq` returns to 0 in the same cycle in which a falling edge restores `ac_present`. It never rises if presence was never reached since reset.
- R7: A level change of `cmp_level` that lasts fewer than FILT_LEN consecutive clock cycles is discarded. It neither restarts the countdown nor sets presence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_level | input | 1 | Asynchronous comparator output; high while the mains sample exceeds the reference |
| ac_present | output | 1 | 1 while a qualified falling edge has been seen within the timeout window |
| ac_fail_irq | output | 1 | Sticky interrupt level raised when presence is lost |

## Verification
Corrupted state in the glitch filter shows up as an edge that is lost or invented. That error reaches `ac_present` within about SYNC_STAGES + FILT_LEN cycles when a restart is missed or spurious, or at the end of the next timeout window when the error is a missed restart. A countdown that is loaded or decremented wrongly moves the drop of `ac_present` away from TIMEOUT_CYCLES after the last edge. A wrong interrupt flag shows as `ac_fail_irq` being set while `ac_present` is 1, or as the flag failing to clear on the restoring edge. The bench therefore compares both outputs on every cycle outside a small band around each expected transition.

// File: rtl/acmon_pkg.sv
package acmon_pkg;

    // 27 ms at 250 MHz
    localparam int unsigned DEF_TIMEOUT_CYCLES = 6_750_000;
    localparam int unsigned DEF_SYNC_STAGES    = 2;
    localparam int unsigned DEF_FILT_LEN       = 4;

    typedef struct packed {
        logic irq;
    } mon_state_t;

endpackage

// File: rtl/acmon_sync.sv
module acmon_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_q, st_d;

    always_comb begin
        st_d          = st_q;
        st_d.chain    = st_q.chain << 1;
        st_d.chain[0] = async_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];
endmodule

// File: rtl/acmon_filter.sv
module acmon_filter #(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    output logic level,
    output logic fall_pulse
);
    localparam int unsigned CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
        logic          fall;
    } filt_state_t;

    filt_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.fall = 1'b0;
        if (sample != st_q.lvl) begin
            if (st_q.cnt == LAST) begin
                st_d.lvl  = sample;
                st_d.cnt  = '0;
                st_d.fall = st_q.lvl & ~sample;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level      = st_q.lvl;
    assign fall_pulse = st_q.fall;

    // R2: a restart pulse only marks a genuine high-to-low step of the filtered level
    assert_fall_is_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |-> (!level && $past(level)));

    // R7: the filtered level only takes a value the synchronised sample already had
    assert_level_follows_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> (level == $past(sample)));
endmodule

// File: rtl/acmon_timer.sv
module acmon_timer #(
    parameter int unsigned TIMEOUT_CYCLES = 6_750_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic running,
    output logic expire
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (restart) begin
            st_d.run = 1'b1;
            st_d.cnt = LOAD;
        end else if (st_q.run) begin
            if (st_q.cnt == '0) begin
                st_d.run = 1'b0;
                expire   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = st_q.run;

    // R2: a restart always leaves the countdown running
    assert_restart_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> running);

    // R4: expiry stops the countdown on the next edge
    assert_expire_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !running);

    // R4: the count never exceeds the loaded window
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (st_q.cnt < CW'(TIMEOUT_CYCLES)));
endmodule

// File: rtl/mains_presence_monitor.sv
module mains_presence_monitor
    import acmon_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = DEF_TIMEOUT_CYCLES,
    parameter int unsigned SYNC_STAGES    = DEF_SYNC_STAGES,
    parameter int unsigned FILT_LEN       = DEF_FILT_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_level,
    output logic ac_present,
    output logic ac_fail_irq
);
    logic cmp_sync;
    logic filt_level;
    logic fall_pulse;
    logic tmr_running;
    logic tmr_expire;

    acmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_level),
        .sync_out (cmp_sync)
    );

    acmon_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (cmp_sync),
        .level      (filt_level),
        .fall_pulse (fall_pulse)
    );

    acmon_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fall_pulse),
        .running (tmr_running),
        .expire  (tmr_expire)
    );

    mon_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (tmr_expire) st_d.irq = 1'b1;
        if (fall_pulse) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ac_present  = tmr_running;
    assign ac_fail_irq = st_q.irq;

    // R5: the interrupt rises only together with the loss of presence
    assert_irq_on_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ac_fail_irq) |-> $fell(ac_present));

    // R5: interrupt and presence are never both asserted
    assert_irq_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ac_fail_irq |-> !ac_present);

    // R6: a restored presence always finds the interrupt cleared
    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ac_present) |-> !ac_fail_irq);
endmodule

// File: tb/tb_mains_presence_monitor.sv
module tb_mains_presence_monitor;
    localparam int TIMEOUT = 200;
    localparam int SYNC    = 2;
    localparam int FILT    = 4;
    localparam int LAT     = SYNC + FILT + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_level = 1'b0;
    logic ac_present, ac_fail_irq;

    int vectors = 0;
    int errors = 0;
    int cyc = 0;
    int last_fall = -1;
    bit prev_v = 1'b0;
    bit cur = 1'b0;
    bit auto_en = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mains_presence_monitor #(
        .TIMEOUT_CYCLES (TIMEOUT),
        .SYNC_STAGES    (SYNC),
        .FILT_LEN       (FILT)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_level   (cmp_level),
        .ac_present  (ac_present),
        .ac_fail_irq (ac_fail_irq)
    );

    task automatic check(input bit act, input bit exp, input string req, input string what);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cyc, act, exp);
        end
    endtask

    function automatic int exp_state(input int now, input int lf);
        int d;
        if (lf < 0) return 0;
        d = now - lf;
        if (d >= LAT + 2 && d <= TIMEOUT + 4) return 1;
        if (d >= TIMEOUT + LAT + 6) return 2;
        return -1;
    endfunction

    task automatic tick(input bit v, input bit rec);
        int e;
        @(negedge clk);
        cyc++;
        if (auto_en) begin
            e = exp_state(cyc, last_fall);
            if (e == 0) begin
                check(ac_present, 1'b0, "R1", "ac_present before any edge");
                check(ac_fail_irq, 1'b0, "R6", "irq without prior presence");
            end else if (e == 1) begin
                check(ac_present, 1'b1, "R3", "ac_present inside window");
                check(ac_fail_irq, 1'b0, "R6", "irq while present");
            end else if (e == 2) begin
                check(ac_present, 1'b0, "R4", "ac_present after timeout");
                check(ac_fail_irq, 1'b1, "R5", "sticky irq after loss");
            end
        end
        if (rec && prev_v && !v) last_fall = cyc;
        prev_v = v;
        cmp_level = v;
    endtask

    task automatic hold(input bit v, input int n);
        for (int i = 0; i < n; i++) tick(v, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
        finish_run();
    end

    initial begin
        int seed;
        int n;
        int len;
        seed = $urandom(32'h5eed_a11c);
        repeat (4) @(negedge clk);
        check(ac_present, 1'b0, "R1", "reset ac_present");
        check(ac_fail_irq, 1'b0, "R1", "reset irq");
        rst_n = 1'b1;
        auto_en = 1'b1;

        // R1: rising edge and steady high give no presence
        hold(1'b1, TIMEOUT + 50);
        check(ac_present, 1'b0, "R1", "after rise only");

        // R7: short low dips while high are discarded
        for (int k = 0; k < 20; k++) begin
            for (int g = 0; g < FILT - 1; g++) tick(1'b0, 1'b0);
            for (int g = 0; g < 15; g++) tick(1'b1, 1'b0);
        end
        check(ac_present, 1'b0, "R7", "after sub-filter dips");
        check(ac_fail_irq, 1'b0, "R7", "irq after dips");

        // R2: a qualified fall sets presence
        hold(1'b0, LAT);
        check(ac_present, 1'b1, "R2", "presence after first fall");

        // R4: a rise inside the window does not restart
        hold(1'b0, 20);
        hold(1'b1, TIMEOUT + 40);
        check(ac_present, 1'b0, "R4", "rise did not restart");
        check(ac_fail_irq, 1'b1, "R5", "irq on loss");

        // R6: the next fall restores presence and clears the interrupt
        hold(1'b0, LAT);
        check(ac_present, 1'b1, "R6", "presence restored");
        check(ac_fail_irq, 1'b0, "R6", "irq cleared by return");
        cur = 1'b0;

        // random square waves and dropouts
        for (int s = 0; s < 60; s++) begin
            if ($urandom_range(0, 3) == 0) begin
                cur = $urandom_range(0, 1);
                hold(cur, $urandom_range(TIMEOUT + 20, TIMEOUT + 150));
            end else begin
                n = $urandom_range(2, 12);
                for (int k = 0; k < n; k++) begin
                    cur = ~cur;
                    len = $urandom_range(FILT + 2, 90);
                    hold(cur, len);
                end
            end
        end
        finish_run();
    end
endmodule